// File: doc/BRIEF.md
# Dual-Path Event Timestamp Latch

This block holds one time-of-day sample for each of two traffic directions, receive and transmit. A classifier outside the block raises a one-cycle event strobe when it sees a packet that needs a timestamp. The block copies the free-running 64-bit time input into that direction's slot and marks the slot full. While a slot is full it keeps its first sample and drops every later strobe. The slot is emptied only when software releases it.

Software reaches the block through a small word-addressed register port. Writes take effect at the next clock edge. Reads are combinational from the read address. Each direction has four registers:

| Word offset | Name | Meaning |
|---|---|---|
| 0 | status | bit 16 is the full flag |
| 1 | data low | low half of the sample |
| 2 | data high | high half of the sample |
| 3 | enable | bit 0 is the capture enable |

Receive uses word addresses 0 to 3 and transmit uses 4 to 7. Each slot is a two-state machine. SLOT_EMPTY moves to SLOT_HELD on a *capture*: a strobe arrives while the direction is enabled and no flush is pending. SLOT_HELD moves back to SLOT_EMPTY on a *flush*. A flush is either a status write with bit 16 set, or any write to the enable register. In every other case each state stays where it is.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset both slots are empty, both enables read 0, and every register reads 0.
- R2: A strobe in cycle t on an enabled, empty direction with no flush in cycle t fills the slot at the end of cycle t. From cycle t+1, status bit 16 reads 1, data low reads time bits 31:0 of cycle t, and data high reads bits 63:32.
- R3: While a slot is full, further strobes on that direction are dropped and the held sample does not change.
- R4: A status write with bit 16 set empties that direction's slot at the next edge. A status write with bit 16 clear has no effect.
- R5: If a flush and a strobe fall in the same cycle on one direction, the flush wins and the slot is empty afterwards.
- R6: Enable bit 0 gates capture for its own direction only. With the enable at 0, strobes are ignored. The enable read back shows bit 0 as last written. Capture uses the enable value held before a write in the same cycle.
- R7: Any write to a direction's enable register discards that direction's held sample.
- R8: While a slot is empty, its data low and data high registers read 0. Status bits other than 16 always read 0.
- R9: Each operation acts on its own direction alone. Strobes, flushes and enable writes on one direction never change the state of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Free-running time value to sample |
| rx_event | input | 1 | Receive-direction capture strobe |
| tx_event | input | 1 | Transmit-direction capture strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read word address |
| reg_rdata | output | 32 | Register read data, combinational from reg_raddr |

## Verification
Every change of state is due exactly one rising edge after the cycle in which its strobe or write was presented. Register reads reflect that new state with no further delay. The bench drives the inputs for cycle t at a falling edge. At the next falling edge it sweeps the read address over all eight words, comparing each against a model advanced by the same one-edge rule. This means a capture, a release or an enable write is judged in the first cycle it may be visible, and never earlier. Coincident strobe-and-flush cases and enable writes made in the same cycle as a strobe are driven directly, then mixed into seeded random traffic.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        OFS_STATUS = 2'd0,
        OFS_DLO    = 2'd1,
        OFS_DHI    = 2'd2,
        OFS_ENABLE = 2'd3
    } reg_ofs_e;

    localparam int unsigned VALID_BIT = 16;

endpackage

// File: rtl/ts_slot.sv
module ts_slot
    import ts_cap_pkg::*;
#(
    parameter int unsigned TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              en,
    input  logic              flush,
    input  logic [TIME_W-1:0] time_in,
    output logic              valid,
    output logic [TIME_W-1:0] stamp
);

    slot_state_e state_q, state_d;
    logic        capture;

    assign capture = evt && en && !flush && (state_q == SLOT_EMPTY);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (capture) state_d = SLOT_HELD;
            SLOT_HELD:  if (flush)   state_d = SLOT_EMPTY;
            default:                 state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       stamp <= '0;
        else if (capture) stamp <= time_in;
    end

    assign valid = (state_q == SLOT_HELD);

    a_r2_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && en && !valid && !flush) |=> (valid && stamp == $past(time_in)));

    a_r3_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !flush) |=> (valid && $stable(stamp)));

    a_r5_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid);

    a_r6_disabled_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !valid) |=> !valid);

endmodule

// File: rtl/ts_regfile.sv
module ts_regfile
    import ts_cap_pkg::*;
#(
    parameter int unsigned PATHS  = 2,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TIME_W = 64,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             waddr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [ADDR_W-1:0]             raddr,
    input  logic [PATHS-1:0]              valid,
    input  logic [PATHS-1:0][TIME_W-1:0]  stamp,
    output logic [PATHS-1:0]              flush,
    output logic [PATHS-1:0]              en,
    output logic [DATA_W-1:0]             rdata
);

    localparam int unsigned PW = ADDR_W - 2;

    logic [PW-1:0] wpath, rpath;
    reg_ofs_e      wofs, rofs;
    logic [PATHS-1:0] en_wr;

    assign wpath = waddr[ADDR_W-1:2];
    assign wofs  = reg_ofs_e'(waddr[1:0]);
    assign rpath = raddr[ADDR_W-1:2];
    assign rofs  = reg_ofs_e'(raddr[1:0]);

    always_comb begin
        for (int p = 0; p < PATHS; p++) begin
            en_wr[p] = wr && (wpath == PW'(p)) && (wofs == OFS_ENABLE);
            flush[p] = en_wr[p] ||
                       (wr && (wpath == PW'(p)) && (wofs == OFS_STATUS) && wdata[VALID_BIT]);
        end
    end

    generate
        for (genvar g = 0; g < PATHS; g++) begin : g_en
            always_ff @(posedge clk) begin
                if (!rst_n)       en[g] <= 1'b0;
                else if (en_wr[g]) en[g] <= wdata[0];
            end

            a_r6_enable_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && waddr == ADDR_W'(4*g + 3)) |=> (en[g] == $past(wdata[0])));
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (int'(rpath) < PATHS) begin
            unique case (rofs)
                OFS_STATUS: rdata[VALID_BIT] = valid[rpath];
                OFS_DLO:    if (valid[rpath]) rdata = stamp[rpath][DATA_W-1:0];
                OFS_DHI:    if (valid[rpath]) rdata = stamp[rpath][TIME_W-1:DATA_W];
                OFS_ENABLE: rdata[0] = en[rpath];
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
    import ts_cap_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TIME_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_now,
    input  logic              rx_event,
    input  logic              tx_event,
    input  logic              reg_wr,
    input  logic [2:0]        reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int unsigned PATHS  = 2;
    localparam int unsigned ADDR_W = $clog2(PATHS) + 2;

    logic [PATHS-1:0]             evt, valid, flush, en;
    logic [PATHS-1:0][TIME_W-1:0] stamp;

    assign evt = {tx_event, rx_event};

    generate
        for (genvar g = 0; g < PATHS; g++) begin : g_slot
            ts_slot #(.TIME_W(TIME_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .evt     (evt[g]),
                .en      (en[g]),
                .flush   (flush[g]),
                .time_in (time_now),
                .valid   (valid[g]),
                .stamp   (stamp[g])
            );
        end
    endgenerate

    ts_regfile #(
        .PATHS  (PATHS),
        .DATA_W (DATA_W),
        .TIME_W (TIME_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (reg_raddr),
        .valid (valid),
        .stamp (stamp),
        .flush (flush),
        .en    (en),
        .rdata (reg_rdata)
    );

    a_r9_flush_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (flush[0] && !flush[1] && valid[1]) |=> valid[1]);

endmodule

// File: tb/tb_ts_capture_latch.sv
`timescale 1ns/1ps
module tb_ts_capture_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic        rx_event = 1'b0, tx_event = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0, reg_raddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int vectors = 0;
    int fails = 0;

    logic        m_valid [2];
    logic [63:0] m_data  [2];
    logic        m_en    [2];

    always #2.5 clk = ~clk;

    ts_capture_latch dut (
        .clk(clk), .rst_n(rst_n), .time_now(time_now),
        .rx_event(rx_event), .tx_event(tx_event),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] expect_word(input int a);
        int p = a / 4;
        int o = a % 4;
        logic [31:0] w = '0;
        case (o)
            0: w[16] = m_valid[p];
            1: w = m_valid[p] ? m_data[p][31:0]  : 32'h0;
            2: w = m_valid[p] ? m_data[p][63:32] : 32'h0;
            default: w[0] = m_en[p];
        endcase
        return w;
    endfunction

    task automatic check_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            reg_raddr = 3'(a);
            #0.1;
            vectors++;
            if (reg_rdata !== expect_word(a)) begin
                fails++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, expect_word(a));
            end
        end
    endtask

    task automatic step(input logic wr, input int addr, input logic [31:0] wd,
                        input logic rxe, input logic txe, input string tag);
        logic flush [2];
        logic evt [2];
        reg_wr = wr; reg_waddr = 3'(addr); reg_wdata = wd;
        rx_event = rxe; tx_event = txe;
        time_now = {$urandom, $urandom};
        evt[0] = rxe; evt[1] = txe;
        for (int p = 0; p < 2; p++) begin
            flush[p] = wr && (addr / 4 == p) && ((addr % 4 == 3) || (addr % 4 == 0 && wd[16]));
            if (flush[p])                          m_valid[p] = 1'b0;
            else if (evt[p] && m_en[p] && !m_valid[p]) begin
                m_valid[p] = 1'b1;
                m_data[p]  = time_now;
            end
            if (wr && addr == p * 4 + 3) m_en[p] = wd[0];
        end
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; rx_event = 1'b0; tx_event = 1'b0;
        check_all(tag);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < 2; p++) begin
            m_valid[p] = 1'b0; m_data[p] = '0; m_en[p] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset state");

        step(0, 0, 0, 1, 1, "R6 strobes while disabled");
        step(1, 3, 32'h1, 0, 0, "R6 enable rx");
        step(0, 0, 0, 0, 1, "R9 tx strobe with tx disabled");
        step(0, 0, 0, 1, 0, "R2 rx capture");
        step(0, 0, 0, 1, 0, "R3 later strobe dropped");
        step(1, 0, 32'hFFFE_FFFF, 1, 0, "R4 status write without bit 16");
        step(1, 4, 32'h0001_0000, 0, 0, "R9 tx release leaves rx");
        step(1, 0, 32'h0001_0000, 1, 0, "R5 release beats strobe");
        step(0, 0, 0, 1, 0, "R2 capture after release");
        step(1, 7, 32'h1, 0, 1, "R6 enable write same cycle as strobe");
        step(0, 0, 0, 0, 1, "R2 tx capture");
        step(1, 7, 32'h1, 0, 0, "R7 enable write discards held");
        step(1, 3, 32'h0, 1, 0, "R7 disable rx discards and R6 uses old enable");
        step(0, 0, 0, 1, 0, "R6 rx disabled ignores strobe");
        step(0, 0, 0, 0, 1, "R8 tx capture then data visible");
        step(1, 4, 32'h0001_0000, 0, 0, "R8 data reads zero once empty");

        for (int i = 0; i < 3000; i++) begin
            logic wr = ($urandom % 4) == 0;
            int   ad = $urandom % 8;
            logic [31:0] wd = $urandom;
            if (($urandom % 3) == 0) wd[0] = 1'b1;
            step(wr, ad, wd, ($urandom % 3) == 0, ($urandom % 3) == 0,
                 "R2 R3 R4 R5 R6 R7 R8 R9 random traffic");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule